// File: doc/BRIEF.md
# Two-Phase Carry-Skip Chain Adder

This block adds two 69-bit operands and returns a 70-bit result. One operand comes from a data bus. The other comes from a holding register. Before the add, the holding-register operand can be replaced by zero. The carry into the lowest bit is either an explicit control bit or the sign bit of the holding-register operand. The sign option supports two's-complement subtraction when the register side has already been inverted.

The datapath is made of small bit groups. The lowest three bits form a group on their own, and the bits above them are split into groups of four (the top group may be narrower). Inside a group, each bit position has one two-input mux. The mux passes the incoming carry when the bit's propagate term is set, and otherwise passes the bus bit itself. This single choice covers both the generate case and the delete case.

Carry nodes are held with inverted polarity, so a high level means "no carry". Every group except the lowest also has a skip term. The skip term produces the group's carry-out directly when all of the group's propagates are set and a carry arrives.

An add takes two clock cycles. A start pulse captures the operands and the controls, and a precharge cycle follows. During precharge, every propagate is forced high and every carry node is driven to "no carry". The evaluate cycle comes next, and at its closing edge the result is written to the sum register and a one-cycle valid flag is raised.

Top module: `skad_adder`

## Requirements
- R1: One cycle after an add completes, `sum_q` equals bus operand + effective register operand + carry-in, computed over IN_W+1 bits. Bit IN_W holds the carry out of the top bit position.
- R2: When `force_zero` is 1 at the accepting edge, the effective register operand is zero. The result is then bus operand + carry-in.
- R3: When `cin_from_sign` is 0, the carry-in is `cin_value`. When it is 1, the carry-in is bit IN_W-1 of the effective register operand, which is 0 under force-zero.
- R4: A start accepted at clock edge k gives `valid_q` = 1 after edge k+2, and `valid_q` stays high for exactly one cycle.
- R5: Operands and controls are sampled only at the accepting edge. Changing them afterwards does not change the result of that add.
- R6: A `start` seen while an add is in its precharge or evaluate cycle is ignored. The result is that of the first add, and no extra valid pulse follows.
- R7: During the precharge cycle, every group-boundary carry node reads high ("no carry"). A carry produced by the previous add therefore never reaches the next result.
- R8: When every bit position propagates and the carry-in is 1, the carry passes through all groups. All inverted group-boundary nodes read low during evaluate, and the sum is 2^IN_W.
- R9: After reset, `valid_q` is 0 and `sum_q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an add; accepted only when idle |
| bus_in | input | IN_W | Bus-side operand |
| reg_in | input | IN_W | Holding-register operand |
| force_zero | input | 1 | Replace the register operand by zero |
| cin_from_sign | input | 1 | 1: carry-in is the register operand sign; 0: carry-in is `cin_value` |
| cin_value | input | 1 | Explicit carry-in |
| sum_q | output | IN_W+1 | Registered result |
| valid_q | output | 1 | One-cycle pulse when `sum_q` is loaded |

## Verification
The hardest condition to reach is a carry that has to cross every group through the skip terms. Random operands almost never make all 69 propagate terms high together. The bench therefore builds that case directly by pairing each operand with its bitwise inverse, with the carry-in set.

Leakage of a stale carry across adds is covered by a specific order of adds. A full-carry add is followed immediately by an all-propagate add with no carry-in, and the second result is checked. A narrow 7-bit instance is also swept over every operand pair, so every mux setting and every skip decision is exercised in both polarities.

// File: rtl/skad_pkg.sv
package skad_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_EVAL = 2'd2
  } phase_e;
endpackage

// File: rtl/skad_group.sv
module skad_group #(
  parameter int W        = 4,
  parameter int HAS_SKIP = 1
) (
  input  logic         pre,
  input  logic [W-1:0] f,
  input  logic [W-1:0] b,
  input  logic         n_cin,
  output logic         n_cout,
  output logic [W-1:0] s
);
  logic [W-1:0] half;
  logic [W-1:0] prop;
  logic [W:0]   nc;
  logic         skip_hit;

  always_comb begin
    half  = f ^ b;
    prop  = half | {W{pre}};
    nc[0] = n_cin;
    for (int i = 0; i < W; i++) begin
      // inverted node: pass carry on propagate, else the bus bit decides
      nc[i+1] = prop[i] ? nc[i] : ~f[i];
    end
    skip_hit = (HAS_SKIP != 0) && (&prop) && !n_cin;
    if (pre)
      n_cout = 1'b1;
    else if (skip_hit)
      n_cout = 1'b0;
    else
      n_cout = nc[W];
    s = half ^ ~nc[W-1:0];
  end
endmodule

// File: rtl/skad_core.sv
module skad_core #(
  parameter int IN_W = 69,
  parameter int GRP  = 4,
  parameter int LOW  = 3
) (
  input  logic                  pre,
  input  logic                  cin,
  input  logic                  fz,
  input  logic [IN_W-1:0]       f,
  input  logic [IN_W-1:0]       b,
  output logic [IN_W:0]         sum,
  output logic [((IN_W-LOW+GRP-1)/GRP):0] n_bound
);
  localparam int REST = IN_W - LOW;
  localparam int NGRP = (REST + GRP - 1) / GRP;

  logic [IN_W-1:0] b_eff;
  logic            n_cin0;

  assign b_eff  = fz ? '0 : b;
  assign n_cin0 = pre | ~cin;

  skad_group #(.W(LOW), .HAS_SKIP(0)) u_low (
    .pre   (pre),
    .f     (f[LOW-1:0]),
    .b     (b_eff[LOW-1:0]),
    .n_cin (n_cin0),
    .n_cout(n_bound[0]),
    .s     (sum[LOW-1:0])
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int BASE = LOW + g * GRP;
    localparam int GW   = ((IN_W - BASE) < GRP) ? (IN_W - BASE) : GRP;
    skad_group #(.W(GW), .HAS_SKIP(1)) u_grp (
      .pre   (pre),
      .f     (f[BASE +: GW]),
      .b     (b_eff[BASE +: GW]),
      .n_cin (n_bound[g]),
      .n_cout(n_bound[g+1]),
      .s     (sum[BASE +: GW])
    );
  end

  assign sum[IN_W] = ~n_bound[NGRP];
endmodule

// File: rtl/skad_ctrl.sv
module skad_ctrl
  import skad_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  output phase_e phase_q,
  output logic   accept,
  output logic   load
);
  assign accept = (phase_q == PH_IDLE) && start;
  assign load   = (phase_q == PH_EVAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
    end else begin
      case (phase_q)
        PH_IDLE: if (start) phase_q <= PH_PRE;
        PH_PRE:  phase_q <= PH_EVAL;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/skad_adder.sv
module skad_adder
  import skad_pkg::*;
#(
  parameter int IN_W = 69,
  parameter int GRP  = 4,
  parameter int LOW  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [IN_W-1:0] bus_in,
  input  logic [IN_W-1:0] reg_in,
  input  logic            force_zero,
  input  logic            cin_from_sign,
  input  logic            cin_value,
  output logic [IN_W:0]   sum_q,
  output logic            valid_q
);
  localparam int NGRP = (IN_W - LOW + GRP - 1) / GRP;

  phase_e          phase_q;
  logic            accept;
  logic            load;
  logic [IN_W-1:0] bus_q;
  logic [IN_W-1:0] breg_q;
  logic            fz_q;
  logic            sel_q;
  logic            cex_q;
  logic            cin;
  logic [IN_W:0]   core_sum;
  logic [NGRP:0]   n_bound;

  skad_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .phase_q(phase_q),
    .accept (accept),
    .load   (load)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_q  <= '0;
      breg_q <= '0;
      fz_q   <= 1'b0;
      sel_q  <= 1'b0;
      cex_q  <= 1'b0;
    end else if (accept) begin
      bus_q  <= bus_in;
      breg_q <= reg_in;
      fz_q   <= force_zero;
      sel_q  <= cin_from_sign;
      cex_q  <= cin_value;
    end
  end

  assign cin = sel_q ? (~fz_q & breg_q[IN_W-1]) : cex_q;

  skad_core #(.IN_W(IN_W), .GRP(GRP), .LOW(LOW)) u_core (
    .pre    (phase_q == PH_PRE),
    .cin    (cin),
    .fz     (fz_q),
    .f      (bus_q),
    .b      (breg_q),
    .sum    (core_sum),
    .n_bound(n_bound)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= load;
      if (load) sum_q <= core_sum;
    end
  end
endmodule

// File: rtl/skad_adder_chk.sv
module skad_adder_chk
  import skad_pkg::*;
#(
  parameter int IN_W = 69,
  parameter int NB   = 18
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            valid_q,
  input logic [IN_W:0]   sum_q,
  input phase_e          phase_q,
  input logic [IN_W-1:0] bus_q,
  input logic [IN_W-1:0] breg_q,
  input logic            fz_q,
  input logic            sel_q,
  input logic            cex_q,
  input logic [NB-1:0]   n_bound
);
  logic [IN_W-1:0] eb;
  logic            ecin;
  logic [IN_W:0]   want;

  always_comb begin
    eb   = fz_q ? '0 : breg_q;
    ecin = sel_q ? eb[IN_W-1] : cex_q;
    want = {1'b0, bus_q} + {1'b0, eb} + {{IN_W{1'b0}}, ecin};
  end

  AST_SUM_MATCH: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> sum_q == want); // R1

  AST_FORCE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (valid_q && fz_q) |-> sum_q == ({1'b0, bus_q} + {{IN_W{1'b0}}, (sel_q ? 1'b0 : cex_q)})); // R2

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE && start) |=> ##2 valid_q); // R4

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q); // R4

  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_IDLE) |=> ($stable(bus_q) && $stable(breg_q) && $stable(fz_q))); // R6

  AST_PRECHARGE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_PRE) |-> (&n_bound)); // R7

  AST_FULL_SKIP: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_EVAL && ((bus_q ^ eb) == '1) && ecin) |-> (n_bound == '0)); // R8
endmodule

bind skad_adder skad_adder_chk #(.IN_W(IN_W), .NB(NGRP + 1)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .valid_q(valid_q),
  .sum_q  (sum_q),
  .phase_q(phase_q),
  .bus_q  (bus_q),
  .breg_q (breg_q),
  .fz_q   (fz_q),
  .sel_q  (sel_q),
  .cex_q  (cex_q),
  .n_bound(n_bound)
);

// File: tb/skad_adder_tb.sv
module skad_adder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 69;
  localparam int SW = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic          b_start = 0, b_fz = 0, b_sel = 0, b_cex = 0, b_vld;
  logic [BW-1:0] b_bus = '0, b_reg = '0;
  logic [BW:0]   b_sum;

  logic          s_start = 0, s_fz = 0, s_sel = 0, s_cex = 0, s_vld;
  logic [SW-1:0] s_bus = '0, s_reg = '0;
  logic [SW:0]   s_sum;

  skad_adder #(.IN_W(BW)) u_dut (
    .clk(clk), .rst(rst), .start(b_start), .bus_in(b_bus), .reg_in(b_reg),
    .force_zero(b_fz), .cin_from_sign(b_sel), .cin_value(b_cex),
    .sum_q(b_sum), .valid_q(b_vld)
  );

  skad_adder #(.IN_W(SW)) u_dut_small (
    .clk(clk), .rst(rst), .start(s_start), .bus_in(s_bus), .reg_in(s_reg),
    .force_zero(s_fz), .cin_from_sign(s_sel), .cin_value(s_cex),
    .sum_q(s_sum), .valid_q(s_vld)
  );

  task automatic chk(input bit ok, input string req, input logic [BW:0] act, input logic [BW:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [BW:0] ref_big(input logic [BW-1:0] a, input logic [BW-1:0] b,
                                          input bit fz, input bit sel, input bit cex);
    logic [BW-1:0] eb;
    logic          c;
    eb = fz ? '0 : b;
    c  = sel ? eb[BW-1] : cex;
    return {1'b0, a} + {1'b0, eb} + {{BW{1'b0}}, c};
  endfunction

  function automatic logic [SW:0] ref_small(input logic [SW-1:0] a, input logic [SW-1:0] b,
                                            input bit fz, input bit sel, input bit cex);
    logic [SW-1:0] eb;
    logic          c;
    eb = fz ? '0 : b;
    c  = sel ? eb[SW-1] : cex;
    return {1'b0, a} + {1'b0, eb} + {{SW{1'b0}}, c};
  endfunction

  // start at a negedge, scramble inputs after acceptance (R5), check after the load edge
  task automatic add_big(input logic [BW-1:0] a, input logic [BW-1:0] b,
                         input bit fz, input bit sel, input bit cex, input string req);
    logic [BW:0] exp;
    exp = ref_big(a, b, fz, sel, cex);
    @(negedge clk);
    b_start = 1; b_bus = a; b_reg = b; b_fz = fz; b_sel = sel; b_cex = cex;
    @(negedge clk);
    b_start = 0; b_bus = ~a; b_reg = ~b; b_fz = ~fz; b_sel = ~sel; b_cex = ~cex;
    @(negedge clk);
    chk(b_vld == 1'b0, {req, " R4 early"}, {{BW{1'b0}}, b_vld}, '0);
    @(negedge clk);
    chk(b_vld == 1'b1, {req, " R4 valid"}, {{BW{1'b0}}, b_vld}, {{BW{1'b0}}, 1'b1});
    chk(b_sum == exp, req, b_sum, exp);
  endtask

  task automatic add_small(input logic [SW-1:0] a, input logic [SW-1:0] b,
                           input bit fz, input bit sel, input bit cex, input string req);
    logic [SW:0] exp;
    exp = ref_small(a, b, fz, sel, cex);
    @(negedge clk);
    s_start = 1; s_bus = a; s_reg = b; s_fz = fz; s_sel = sel; s_cex = cex;
    @(negedge clk);
    s_start = 0; s_bus = ~a; s_reg = ~b;
    @(negedge clk);
    @(negedge clk);
    chk(s_vld == 1'b1 && s_sum == exp, req, {{(BW-SW){1'b0}}, s_vld, s_sum[SW-1:0]},
        {{(BW-SW){1'b0}}, 1'b1, exp[SW-1:0]});
    chk(s_sum[SW] == exp[SW], {req, " carry"}, {{BW{1'b0}}, s_sum[SW]}, {{BW{1'b0}}, exp[SW]});
  endtask

  function automatic logic [BW-1:0] rnd69();
    logic [95:0] t;
    t = {$urandom(), $urandom(), $urandom()};
    return t[BW-1:0];
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin : main
    logic [BW-1:0] a, b;
    logic [BW:0]   e1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    chk(b_vld == 0 && b_sum == '0, "R9 reset", b_sum, '0);
    chk(s_vld == 0 && s_sum == '0, "R9 reset small", {{(BW-SW){1'b0}}, s_sum}, '0);

    // R1 directed and random
    add_big('0, '0, 0, 0, 0, "R1 zero");
    add_big({BW{1'b1}}, {BW{1'b1}}, 0, 0, 1, "R1 max+max+1");
    for (int k = 0; k < 24; k++) begin
      a = rnd69(); b = rnd69();
      add_big(a, b, 1'(k[0]), 1'(k[1]), 1'(k[2]), "R1 random");
    end

    // R2 force zero
    add_big(rnd69(), {BW{1'b1}}, 1, 0, 0, "R2 force zero");
    add_big({BW{1'b1}}, rnd69(), 1, 0, 1, "R2 force zero ripple");

    // R3 carry-in source
    add_big(69'd5, {1'b1, 68'd3}, 0, 1, 0, "R3 sign carry set");
    add_big(69'd5, {1'b0, 68'd3}, 0, 1, 1, "R3 sign carry clear");
    add_big(69'd5, {1'b1, 68'd3}, 1, 1, 1, "R3 sign under force zero");
    add_big(69'd5, 69'd3, 0, 0, 1, "R3 explicit carry");

    // R8 all-propagate with carry-in: sum is 2^BW
    a = rnd69();
    add_big(a, ~a, 0, 0, 1, "R8 full skip");
    add_big({BW{1'b0}}, {BW{1'b1}}, 0, 0, 1, "R8 full skip zero bus");

    // R7 full carry then all-propagate without carry-in: no stale carry
    add_big({BW{1'b1}}, 69'd1, 0, 0, 0, "R7 setup");
    a = rnd69();
    add_big(a, ~a, 0, 0, 0, "R7 no leakage");

    // R6 start held during busy cycles is ignored
    a = rnd69(); b = rnd69();
    e1 = ref_big(a, b, 0, 0, 1);
    @(negedge clk);
    b_start = 1; b_bus = a; b_reg = b; b_fz = 0; b_sel = 0; b_cex = 1;
    @(negedge clk);
    b_bus = ~a; b_reg = b ^ 69'h1234;
    @(negedge clk);
    @(negedge clk);
    b_start = 0;
    chk(b_vld == 1 && b_sum == e1, "R6 first result kept", b_sum, e1);
    @(negedge clk);
    chk(b_vld == 0, "R6 no second valid", {{BW{1'b0}}, b_vld}, '0);
    @(negedge clk);
    chk(b_vld == 0, "R6 still idle", {{BW{1'b0}}, b_vld}, '0);

    // exhaustive sweep of the narrow instance (R1, R3, R5, R8)
    for (int i = 0; i < (1 << SW); i++) begin
      for (int j = 0; j < (1 << SW); j++) begin
        add_small(SW'(i), SW'(j), 0, 1'((i ^ j) & 1), 1'((i >> 1) & 1), "R1 sweep");
      end
    end
    for (int i = 0; i < (1 << SW); i++) begin
      add_small(SW'(i), SW'(i * 37), 1, 1'(i & 1), 1'((i >> 2) & 1), "R2 sweep");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule